// File: doc/BRIEF.md
# Transmit Test-Pattern and T3 Alarm Generator

This block chooses the NRZ bit stream that goes to the transmit line encoder. The stream comes either from user data or from an internal generator. The internal generators are steady ones, an alternating one-zero pattern, a complete T3 alarm M-frame, and two pseudo-random sequences of length 2^15-1 and 2^23-1. Three inputs make the choice: a 2-bit pattern select, a line-mode input and a feature enable. One bit leaves the block for each cycle in which the bit enable is high.

The alarm frame is exact to the bit. It has 7 subframes of 8 blocks each, and each block is one overhead bit followed by 84 payload bits. The payload alternates and starts again with a one after every overhead bit. When the chosen source changes, the frame counter and the alternating pattern both start over. A fresh selection of either pattern therefore always begins at its defined first bit.

Top module: `tx_pattern_gen`

## Requirements
- R1: While `rstN` is low and after it is released, `txData` is 0 until the first enabled bit.
- R2: `txData` is a register. It loads the bit of the chosen source on a rising clock edge where `bitEn` is 1 and holds its value otherwise. A generator does not advance on an edge where `bitEn` is 0.
- R3: With `featEn`=1 and `patSel`=2'b00, each emitted bit equals `userData` as sampled on that edge.
- R4: With `featEn`=0, `patSel` is ignored and `userData` is emitted for every select value.
- R5: With `featEn`=1 and `patSel`=2'b01, every emitted bit is 1.
- R6: With `patSel`=2'b10 and `lineMode` set to E3 (2'b00) or STS-1 (2'b10 or 2'b11), the output alternates 1,0,1,0 and starts with 1.
- R7: With `patSel`=2'b10 and `lineMode`=2'b01 (T3), the output is the alarm M-frame. Bit position p within the frame maps to subframe s=p/680, block b=(p%680)/85 and offset k=p%85. When k=0 the bit is an overhead bit. In block 0 of subframes 0 to 6 the overhead bits are 1,1,0,0,0,1,0. In blocks 1 and 7 the overhead bit is 1, and in blocks 2 to 6 it is 0. When k>0 the bit is 1 for odd k and 0 for even k.
- R8: The alarm frame is 4760 bits long and returns to position 0 after its last bit.
- R9: With `patSel`=2'b11 and E3 mode, the emitted stream b satisfies b[n] = b[n-23] XOR b[n-18].
- R10: With `patSel`=2'b11 and T3 or STS-1 mode, the emitted stream b satisfies b[n] = b[n-15] XOR b[n-14].
- R11: A change of the chosen source restarts the alarm frame at position 0 and the alternating pattern at 1. This holds both when the change lands in the same cycle as `bitEn` and when it lands in a cycle without it.
- R12: Neither pseudo-random generator can reach the all-zero state, so a run of 15 zeros (short sequence) or 23 zeros (long sequence) never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Emit one bit on this edge |
| userData | input | 1 | NRZ user data bit |
| patSel | input | 2 | Pattern select code |
| lineMode | input | 2 | 00 E3, 01 T3, 10/11 STS-1 |
| featEn | input | 1 | Enables internal pattern selection |
| txData | output | 1 | Selected NRZ bit |

## Verification
The case that needs care is a source change in the same cycle as a bit enable. In that cycle the restart of the alarm-frame counter or of the alternating phase must win over the normal advance, and the emitted bit must be the pattern's first bit. The bench stops the alarm frame at a position whose next bit is 0, moves to user data and back, and changes the select on an enabled edge. It expects the frame-start values 1,1,0,1. It repeats this for the alternating pattern, and again with the select change placed on an edge without a bit enable.

// File: rtl/tx_pat_pkg.sv
package tx_pat_pkg;

  localparam logic [1:0] LINE_E3 = 2'b00;
  localparam logic [1:0] LINE_T3 = 2'b01;

  typedef enum logic [2:0] {
    SRC_USER   = 3'd0,
    SRC_ONES   = 3'd1,
    SRC_ALT    = 3'd2,
    SRC_AIS    = 3'd3,
    SRC_PRBS15 = 3'd4,
    SRC_PRBS23 = 3'd5
  } srcSel_t;

  typedef struct packed {
    srcSel_t src;
    logic    restart;
    logic    advance;
  } patStrobe_t;

endpackage

// File: rtl/txpat_ctrl.sv
module txpat_ctrl
  import tx_pat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [1:0] patSel,
  input  logic [1:0] lineMode,
  input  logic       featEn,
  output patStrobe_t strobes
);

  srcSel_t curSrc;
  srcSel_t prevSrc;

  always_comb begin
    curSrc = SRC_USER;
    if (featEn) begin
      unique case (patSel)
        2'b00: curSrc = SRC_USER;
        2'b01: curSrc = SRC_ONES;
        2'b10: curSrc = (lineMode == LINE_T3) ? SRC_AIS : SRC_ALT;
        default: curSrc = (lineMode == LINE_E3) ? SRC_PRBS23 : SRC_PRBS15;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevSrc <= SRC_USER;
    else       prevSrc <= curSrc;
  end

  always_comb begin
    strobes.src     = curSrc;
    strobes.restart = (curSrc != prevSrc);
    strobes.advance = bitEn;
  end

endmodule

// File: rtl/txpat_lfsr.sv
module txpat_lfsr #(
  parameter int WIDTH = 15,
  parameter int TAP   = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  output logic bitOut
);

  logic [WIDTH-1:0] state;

  always_ff @(posedge clk) begin
    if (!rstN)     state <= '1;
    else if (step) state <= {state[WIDTH-2:0], state[WIDTH-1] ^ state[TAP-1]};
  end

  assign bitOut = state[WIDTH-1];

  // R12
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    step |=> (state != '0));

endmodule

// File: rtl/txpat_dpath.sv
module txpat_dpath
  import tx_pat_pkg::*;
#(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  parameter int PAYLOAD   = 84,
  parameter logic [SUBFRAMES-1:0] SUB_OH = 7'b0100011,
  parameter logic [BLOCKS-1:0]    BLK_OH = 8'b1000_0010,
  parameter int SHORT_W = 15,
  parameter int SHORT_T = 14,
  parameter int LONG_W  = 23,
  parameter int LONG_T  = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  patStrobe_t strobes,
  input  logic       userData,
  output logic       txData
);

  localparam int SUB_W = (SUBFRAMES > 1) ? $clog2(SUBFRAMES) : 1;
  localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam int BIT_W = $clog2(PAYLOAD + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBFRAMES - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(PAYLOAD);

  // frame position
  logic [SUB_W-1:0] subIdx, effSub, nxtSub;
  logic [BLK_W-1:0] blkIdx, effBlk, nxtBlk;
  logic [BIT_W-1:0] bitIdx, effBit, nxtBit;
  logic             aisStep;
  logic             aisBit;

  assign effSub  = strobes.restart ? '0 : subIdx;
  assign effBlk  = strobes.restart ? '0 : blkIdx;
  assign effBit  = strobes.restart ? '0 : bitIdx;
  assign aisStep = strobes.advance && (strobes.src == SRC_AIS);

  always_comb begin
    nxtSub = effSub;
    nxtBlk = effBlk;
    nxtBit = effBit;
    if (aisStep) begin
      if (effBit == BIT_LAST) begin
        nxtBit = '0;
        if (effBlk == BLK_LAST) begin
          nxtBlk = '0;
          nxtSub = (effSub == SUB_LAST) ? '0 : effSub + 1'b1;
        end else begin
          nxtBlk = effBlk + 1'b1;
        end
      end else begin
        nxtBit = effBit + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subIdx <= '0;
      blkIdx <= '0;
      bitIdx <= '0;
    end else begin
      subIdx <= nxtSub;
      blkIdx <= nxtBlk;
      bitIdx <= nxtBit;
    end
  end

  always_comb begin
    if (effBit == '0) aisBit = (effBlk == '0) ? SUB_OH[effSub] : BLK_OH[effBlk];
    else              aisBit = effBit[0];
  end

  // alternating pattern
  logic altNext, effAlt;
  assign effAlt = strobes.restart ? 1'b1 : altNext;

  always_ff @(posedge clk) begin
    if (!rstN) altNext <= 1'b1;
    else if (strobes.advance && strobes.src == SRC_ALT) altNext <= ~effAlt;
    else altNext <= effAlt;
  end

  // pseudo-random generators
  logic [1:0] prbsBit;
  for (genvar g = 0; g < 2; g++) begin : g_prbs
    localparam int GW = (g == 0) ? SHORT_W : LONG_W;
    localparam int GT = (g == 0) ? SHORT_T : LONG_T;
    localparam srcSel_t GSRC = (g == 0) ? SRC_PRBS15 : SRC_PRBS23;
    txpat_lfsr #(.WIDTH(GW), .TAP(GT)) u_lfsr (
      .clk    (clk),
      .rstN   (rstN),
      .step   (strobes.advance && (strobes.src == GSRC)),
      .bitOut (prbsBit[g])
    );
  end

  // output selection
  logic nextBit;
  always_comb begin
    unique case (strobes.src)
      SRC_ONES:   nextBit = 1'b1;
      SRC_ALT:    nextBit = effAlt;
      SRC_AIS:    nextBit = aisBit;
      SRC_PRBS15: nextBit = prbsBit[0];
      SRC_PRBS23: nextBit = prbsBit[1];
      default:    nextBit = userData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                txData <= 1'b0;
    else if (strobes.advance) txData <= nextBit;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(txData));

  // R3
  user_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.src == SRC_USER) |=> (txData == $past(userData)));

  // R5
  ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.src == SRC_ONES) |=> txData);

  // R11
  restart_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.restart &&
     (strobes.src == SRC_ALT || strobes.src == SRC_AIS)) |=> txData);

endmodule

// File: rtl/tx_pattern_gen.sv
module tx_pattern_gen
  import tx_pat_pkg::*;
#(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  parameter int PAYLOAD   = 84,
  parameter int SHORT_W   = 15,
  parameter int SHORT_T   = 14,
  parameter int LONG_W    = 23,
  parameter int LONG_T    = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       userData,
  input  logic [1:0] patSel,
  input  logic [1:0] lineMode,
  input  logic       featEn,
  output logic       txData
);

  patStrobe_t strobes;

  txpat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .patSel   (patSel),
    .lineMode (lineMode),
    .featEn   (featEn),
    .strobes  (strobes)
  );

  txpat_dpath #(
    .SUBFRAMES (SUBFRAMES),
    .BLOCKS    (BLOCKS),
    .PAYLOAD   (PAYLOAD),
    .SHORT_W   (SHORT_W),
    .SHORT_T   (SHORT_T),
    .LONG_W    (LONG_W),
    .LONG_T    (LONG_T)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .userData (userData),
    .txData   (txData)
  );

endmodule

// File: tb/tx_pattern_gen_tb.sv
module tx_pattern_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       userData = 1'b0;
  logic [1:0] patSel = 2'b00;
  logic [1:0] lineMode = 2'b00;
  logic       featEn = 1'b1;
  logic       txData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  tx_pattern_gen u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .userData(userData),
    .patSel(patSel), .lineMode(lineMode), .featEn(featEn), .txData(txData)
  );

  task automatic check(input string req, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // one edge with given enable and data; returns sampled output
  task automatic edgeOut(input logic en, input logic d, output logic q);
    @(negedge clk);
    bitEn = en;
    userData = d;
    @(posedge clk);
    #1;
    q = txData;
  endtask

  function automatic logic expAis(input int p);
    int s, b, k;
    logic [6:0] subOh;
    s = p / 680;
    b = (p % 680) / 85;
    k = p % 85;
    subOh = 7'b0100011;
    if (k == 0) return (b == 0) ? subOh[s] : ((b == 1) || (b == 7));
    return logic'(k % 2);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    bitEn = 1'b1;
    userData = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", txData, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    bitEn = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after release", txData, 1'b0);
  endtask

  task automatic testUser();
    logic q;
    featEn = 1'b1; patSel = 2'b00;
    for (int i = 0; i < 20; i++) begin
      logic d = logic'((i * 7 + 3) % 5 < 2);
      edgeOut(1'b1, d, q);
      check("R3 user pass", q, d);
    end
  endtask

  task automatic testFeatOff();
    logic q;
    featEn = 1'b0;
    for (int s = 0; s < 4; s++) begin
      patSel = 2'(s);
      lineMode = 2'b01;
      for (int i = 0; i < 6; i++) begin
        logic d = logic'(i == 2 || i == 3);
        edgeOut(1'b1, d, q);
        check("R4 select ignored", q, d);
      end
    end
    featEn = 1'b1;
  endtask

  task automatic testOnes();
    logic q;
    patSel = 2'b01;
    for (int i = 0; i < 16; i++) begin
      edgeOut(1'b1, 1'b0, q);
      check("R5 all ones", q, 1'b1);
    end
  endtask

  task automatic testAlt(input logic [1:0] mode);
    logic q;
    patSel = 2'b00;
    edgeOut(1'b1, 1'b0, q);
    lineMode = mode;
    patSel = 2'b10;
    for (int i = 0; i < 12; i++) begin
      edgeOut(1'b1, 1'b0, q);
      check("R6 alternating", q, logic'(i % 2 == 0));
    end
  endtask

  task automatic testHold();
    logic q, last;
    lineMode = 2'b00; patSel = 2'b00;
    edgeOut(1'b1, 1'b0, q);
    patSel = 2'b10;
    edgeOut(1'b1, 1'b0, q);
    check("R2 first alt", q, 1'b1);
    last = q;
    for (int i = 0; i < 4; i++) begin
      edgeOut(1'b0, 1'b0, q);
      check("R2 hold", q, last);
    end
    edgeOut(1'b1, 1'b0, q);
    check("R2 no advance while idle", q, 1'b0);
  endtask

  task automatic testAis();
    logic q;
    patSel = 2'b00;
    edgeOut(1'b1, 1'b0, q);
    lineMode = 2'b01;
    patSel = 2'b10;
    for (int p = 0; p < 4760 + 100; p++) begin
      if (p == 300 || p == 2000) begin
        edgeOut(1'b0, 1'b0, q);
        edgeOut(1'b0, 1'b0, q);
      end
      edgeOut(1'b1, 1'b0, q);
      if (p < 4760) check("R7 alarm frame", q, expAis(p));
      else          check("R8 frame wrap", q, expAis(p - 4760));
    end
  endtask

  task automatic testPrbs(input logic [1:0] mode, input int w, input int t, input string req);
    logic q;
    logic hist[400];
    int zeroRun, ones;
    lineMode = mode;
    patSel = 2'b11;
    zeroRun = 0; ones = 0;
    for (int n = 0; n < 400; n++) begin
      edgeOut(1'b1, 1'b0, q);
      hist[n] = q;
      if (q) begin ones++; zeroRun = 0; end
      else zeroRun++;
      if (n >= w) check(req, q, hist[n - w] ^ hist[n - t]);
      if (zeroRun >= w) check("R12 zero run", 1'b1, 1'b0);
    end
    check("R12 both values seen", logic'(ones > 100 && ones < 300), 1'b1);
  endtask

  task automatic testRestart();
    logic q;
    // alarm frame: stop at position 2 (next bit 0), leave and return
    patSel = 2'b00;
    edgeOut(1'b1, 1'b0, q);
    lineMode = 2'b01; patSel = 2'b10;
    for (int p = 0; p < 2; p++) edgeOut(1'b1, 1'b0, q);
    patSel = 2'b00;
    edgeOut(1'b1, 1'b0, q);
    check("R11 user between", q, 1'b0);
    patSel = 2'b10;
    for (int p = 0; p < 4; p++) begin
      edgeOut(1'b1, 1'b0, q);
      check("R11 alarm restart same cycle", q, expAis(p));
    end
    // change with no bit enable, then resume
    patSel = 2'b01;
    edgeOut(1'b1, 1'b0, q);
    patSel = 2'b10;
    edgeOut(1'b0, 1'b0, q);
    check("R11 idle change holds", q, 1'b1);
    for (int p = 0; p < 3; p++) begin
      edgeOut(1'b1, 1'b0, q);
      check("R11 alarm restart idle cycle", q, expAis(p));
    end
    // alternating pattern: emit 1,0 then switch away and back
    lineMode = 2'b10;
    edgeOut(1'b1, 1'b0, q);
    edgeOut(1'b1, 1'b0, q);
    edgeOut(1'b1, 1'b0, q);
    check("R11 alt before switch", q, 1'b1);
    patSel = 2'b00;
    edgeOut(1'b1, 1'b1, q);
    patSel = 2'b10;
    edgeOut(1'b1, 1'b0, q);
    check("R11 alt restarts with one", q, 1'b1);
    edgeOut(1'b1, 1'b0, q);
    check("R11 alt second bit", q, 1'b0);
  endtask

  initial begin
    doReset();
    testUser();
    testFeatOff();
    testOnes();
    testAlt(2'b00);
    testAlt(2'b10);
    testHold();
    testAis();
    testPrbs(2'b00, 23, 18, "R9 long sequence");
    testPrbs(2'b01, 15, 14, "R10 short sequence T3");
    testPrbs(2'b10, 15, 14, "R10 short sequence STS-1");
    testRestart();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule